// File: doc/BRIEF.md
# Interlocked Handshake Bus Master

This block runs the requester side of a self-timed bus on which no clock is shared with the responder. A local client hands over one transfer at a time: an address, a direction and, for stores, a data word. The block drives these onto the bus. It then walks the master-ready line through a full interlock against the responder's slave-ready reply. It returns one response pulse with the loaded word, or with an error flag when the responder stays silent.

All timing is counted in clock cycles of the local clock. `SKEW_CYC` covers the worst-case skew between bus lines. `SETUP_CYC` covers the setup margin of the capture register. `TMO_CYC` bounds the wait for a reply. The slave-ready input comes through a two-stage synchronizer, so the state machine sees it three clock edges after it changes. Because the responder decides how long each transfer lasts, fast and slow responders share the bus with no change to the master.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole transfer, and a requester must hold its request until it sees ready. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the requester must take when it comes.

Top module: `hsk_bus_master`

## Requirements
- R1: While `rst_n` is low and after it rises with no request, `req_ready` is 1 and `busy`, `bus_drive`, `bus_mrdy` and `rsp_valid` are 0.
- R2: In the cycle after acceptance, `bus_drive` is 1, `bus_addr` carries the request address, and `bus_rw` is 1 for a read and 0 for a write. For a write, `bus_wen` is 1 and `bus_wdata` carries the data. `bus_mrdy` rises exactly `SKEW_CYC` clock edges after `bus_drive` rises.
- R3: `bus_addr`, `bus_rw`, `bus_wdata` and `bus_wen` stay unchanged for as long as `bus_drive` is 1.
- R4: On a read, `bus_mrdy` falls exactly 3+`SKEW_CYC`+`SETUP_CYC` edges after `bus_srdy` rises. `bus_rdata` as sampled on that edge appears on `rsp_rdata` with the response pulse. This holds for any responder delay shorter than the timeout.
- R5: On a write, `bus_mrdy` falls exactly 3 edges after `bus_srdy` rises, and the response carries `rsp_rdata` = 0.
- R6: After `bus_mrdy` falls, `bus_drive` stays 1 for exactly `SKEW_CYC` more edges and then falls.
- R7: `rsp_valid` is a one-cycle pulse. It rises exactly 3 edges after `bus_srdy` returns low, and never earlier. `busy` stays 1 until that pulse.
- R8: If no synchronized slave-ready arrives within `TMO_CYC` edges of `bus_mrdy` rising, `bus_mrdy` falls on exactly the `TMO_CYC`-th edge. The response then carries `rsp_err` = 1 and `rsp_rdata` = 0. `rsp_err` is 0 on every completed transfer and is never 1 outside the pulse.
- R9: `req_ready` equals the inverse of `busy`. A `req_valid` raised while busy is ignored: it changes neither the bus fields nor the number of transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Transfer timed out |
| rsp_rdata | output | DW | Loaded word, 0 for stores and errors |
| busy | output | 1 | Transfer in progress |
| bus_addr | output | AW | Address lines |
| bus_rw | output | 1 | Command line, 1 = read, 0 = write |
| bus_wdata | output | DW | Write data lines |
| bus_wen | output | 1 | Write data is being driven |
| bus_drive | output | 1 | Address and command are being driven |
| bus_mrdy | output | 1 | Master-ready |
| bus_srdy | input | 1 | Slave-ready, asynchronous |
| bus_rdata | input | DW | Read data lines |

## Verification
The assertions assume a responder that keeps to the interlock. It raises slave-ready only while master-ready is high. It holds the read data steady while slave-ready is high. It lowers slave-ready only after master-ready has fallen. The bench models such a responder itself. It drives its lines only on falling clock edges, waits a random delay shorter than the timeout before replying, and releases at least `SKEW_CYC` cycles after master-ready falls. The timeout cases leave slave-ready low throughout.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_WAIT,
    ST_SETTLE,
    ST_TAIL,
    ST_RELEASE
  } hsk_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/hsk_gap_timer.sv
module hsk_gap_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/hsk_bus_master.sv
module hsk_bus_master
  import hsk_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned SKEW_CYC  = 2,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned TMO_CYC   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wen,
  output logic          bus_drive,
  output logic          bus_mrdy,
  input  logic          bus_srdy,
  input  logic [DW-1:0] bus_rdata
);
  localparam int unsigned SAMP_CYC = SKEW_CYC + SETUP_CYC;
  localparam int unsigned MAXV     = (TMO_CYC > SAMP_CYC) ? TMO_CYC : SAMP_CYC;
  localparam int unsigned TW       = $clog2(MAXV + 1);
  localparam logic [TW-1:0] L_SKEW = TW'(SKEW_CYC - 1);
  localparam logic [TW-1:0] L_SAMP = TW'(SAMP_CYC - 1);
  localparam logic [TW-1:0] L_TMO  = TW'(TMO_CYC - 1);

  hsk_state_e    state;
  logic          srdy_s;
  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_exp;
  logic          rw_q;
  logic          err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_srdy), .q(srdy_s)
  );

  hsk_gap_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = L_SKEW;
    unique case (state)
      ST_IDLE: t_load = req_valid;
      ST_LEAD: begin
        t_load = t_exp;
        t_val  = L_TMO;
      end
      ST_WAIT: begin
        t_load = srdy_s || t_exp;
        t_val  = (srdy_s && rw_q) ? L_SAMP : L_SKEW;
      end
      ST_SETTLE: t_load = t_exp;
      default: t_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rw_q      <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          rw_q    <= ~req_write;
          wdata_q <= req_wdata;
          err_q   <= 1'b0;
          rdata_q <= '0;
          state   <= ST_LEAD;
        end
        ST_LEAD: if (t_exp) state <= ST_WAIT;
        ST_WAIT: begin
          if (srdy_s)     state <= rw_q ? ST_SETTLE : ST_TAIL;
          else if (t_exp) begin
            err_q <= 1'b1;
            state <= ST_TAIL;
          end
        end
        ST_SETTLE: if (t_exp) begin
          rdata_q <= bus_rdata;
          state   <= ST_TAIL;
        end
        ST_TAIL: if (t_exp) state <= ST_RELEASE;
        ST_RELEASE: if (!srdy_s) begin
          rsp_valid <= 1'b1;
          rsp_err   <= err_q;
          rsp_rdata <= (rw_q && !err_q) ? rdata_q : '0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);
  assign bus_drive = (state == ST_LEAD) || (state == ST_WAIT) ||
                     (state == ST_SETTLE) || (state == ST_TAIL);
  assign bus_mrdy  = (state == ST_WAIT) || (state == ST_SETTLE);
  assign bus_addr  = addr_q;
  assign bus_rw    = rw_q;
  assign bus_wdata = wdata_q;
  assign bus_wen   = bus_drive && !rw_q;
endmodule

// File: rtl/hsk_bus_master_chk.sv
module hsk_bus_master_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          busy,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rw,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_drive,
  input logic          bus_mrdy
);
  assert_mrdy_inside_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrdy |-> bus_drive);

  assert_mrdy_after_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_mrdy) |-> $past(bus_drive));

  assert_drive_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> $past(req_valid && req_ready));

  assert_fields_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && $past(bus_drive)) |-> ($stable(bus_addr) && $stable(bus_rw) && $stable(bus_wdata)));

  assert_drive_outlasts_mrdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_mrdy) |-> bus_drive);

  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !bus_drive));

  assert_err_in_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  assert_accept_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

bind hsk_bus_master hsk_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .busy(busy),
  .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_wdata(bus_wdata),
  .bus_drive(bus_drive), .bus_mrdy(bus_mrdy)
);

// File: tb/hsk_bus_master_test.sv
`timescale 1ns/1ps
module hsk_bus_master_test;
  localparam int AW = 16, DW = 16, SKEW = 2, SETUP = 1, TMO = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, busy, bus_rw, bus_wen, bus_drive, bus_mrdy;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_srdy = 0;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [AW-1:0] cur_addr;
  logic cur_write;
  logic [DW-1:0] cur_wdata;
  bit stab_bad, early_rsp;

  always #4 clk = ~clk;

  hsk_bus_master #(.AW(AW), .DW(DW), .SKEW_CYC(SKEW), .SETUP_CYC(SETUP), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .busy(busy),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_wdata(bus_wdata), .bus_wen(bus_wen),
    .bus_drive(bus_drive), .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy), .bus_rdata(bus_rdata)
  );

  function automatic logic [DW-1:0] resp_word(input logic [AW-1:0] a);
    return DW'((a * 16'd29) ^ 16'hA55A);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sel: 0 mrdy high, 1 mrdy low, 2 drive low, 3 rsp_valid high
  task automatic count_edges(input int sel, output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      bit hit;
      @(posedge clk); n++;
      @(negedge clk);
      if (bus_drive && (bus_addr !== cur_addr || bus_rw !== !cur_write ||
          bus_wen !== cur_write || (cur_write && bus_wdata !== cur_wdata))) stab_bad = 1;
      if (sel != 3 && rsp_valid) early_rsp = 1;
      case (sel)
        0: hit = bus_mrdy;
        1: hit = !bus_mrdy;
        2: hit = !bus_drive;
        default: hit = rsp_valid;
      endcase
      if (hit) break;
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int dly, input bit tmo, input bit junk, input int rel);
    int n;
    logic [DW-1:0] exp_rd;
    exp_rd = resp_word(a);
    cur_addr = a; cur_write = wr; cur_wdata = d; stab_bad = 0; early_rsp = 0;
    @(negedge clk);
    chk(req_ready == 1 && busy == 0, "R9 ready when idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    if (junk) begin
      req_valid = 1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
    end else req_valid = 0;
    chk(bus_drive && busy && !req_ready, "R2 drive after accept", {bus_drive, busy, req_ready}, 3'b110);
    chk(bus_addr == a && bus_rw == !wr, "R2 addr/rw", {bus_addr, bus_rw}, {a, !wr});
    if (wr) chk(bus_wen && bus_wdata == d, "R2 write data", bus_wdata, d);
    count_edges(0, n);
    chk(n == SKEW, "R2 mrdy lead", n, SKEW);
    if (tmo) begin
      count_edges(1, n);
      chk(n == TMO, "R8 timeout length", n, TMO);
      req_valid = 0;
    end else begin
      for (int i = 0; i < dly; i++) begin
        bus_rdata = DW'($urandom);
        @(negedge clk);
        if (junk) chk(!req_ready, "R9 busy blocks request", req_ready, 0);
      end
      bus_srdy = 1; bus_rdata = exp_rd;
      count_edges(1, n);
      req_valid = 0;
      if (wr) chk(n == 3, "R5 write mrdy fall", n, 3);
      else    chk(n == 3 + SKEW + SETUP, "R4 read mrdy fall", n, 3 + SKEW + SETUP);
    end
    count_edges(2, n);
    chk(n == SKEW, "R6 hold after mrdy", n, SKEW);
    if (!tmo) begin
      for (int i = 0; i < rel; i++) @(negedge clk);
      chk(busy && !rsp_valid && !early_rsp, "R7 no early response", rsp_valid, 0);
      bus_srdy = 0; bus_rdata = DW'($urandom);
      count_edges(3, n);
      chk(n == 3, "R7 response after release", n, 3);
    end else begin
      count_edges(3, n);
      chk(!early_rsp, "R7 no early response", early_rsp, 0);
    end
    chk(rsp_err == tmo, "R8 error flag", rsp_err, tmo);
    chk(rsp_rdata == ((wr || tmo) ? '0 : exp_rd), "R4 read result", rsp_rdata,
        (wr || tmo) ? 0 : exp_rd);
    chk(!busy && req_ready, "R9 idle after response", busy, 0);
    chk(!stab_bad, "R3 bus fields stable", stab_bad, 0);
    @(posedge clk); @(negedge clk);
    chk(!rsp_valid && !bus_drive, "R7 single pulse / R9 junk ignored", {rsp_valid, bus_drive}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !bus_drive && !bus_mrdy && !rsp_valid, "R1 in reset",
        {req_ready, busy, bus_drive, bus_mrdy, rsp_valid}, 5'b10000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !bus_drive && !bus_mrdy && !rsp_valid, "R1 after reset",
        {req_ready, busy, bus_drive, bus_mrdy, rsp_valid}, 5'b10000);
    // directed corners
    xfer(0, 16'h0001, 16'h0000, 0, 0, 0, SKEW);
    xfer(1, 16'hFFFF, 16'hBEEF, 0, 0, 0, SKEW);
    xfer(0, 16'h8000, 16'h0000, 30, 0, 1, SKEW + 3);
    xfer(0, 16'h1234, 16'h0000, 0, 1, 0, 0);
    xfer(1, 16'h4321, 16'hCAFE, 0, 1, 1, 0);
    xfer(1, 16'h00F0, 16'h1357, 12, 0, 1, SKEW + 1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      xfer(1'($urandom), AW'($urandom), DW'($urandom), int'($urandom % 25),
           ($urandom % 8) == 0, 1'($urandom), SKEW + int'($urandom % 4));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule